// File: doc/BRIEF.md
# Multi-queue inter-processor mailbox

A mailbox through which several processors swap short 32-bit messages. It holds a parameterized set of hardware queues, each four words deep. Any processor on a simple register bus can push a word into a queue, and another processor can pop it. Per-queue registers report the fill level, a sticky overflow flag and a full flag.

Every user (a target processor) owns one level-sensitive, active-high interrupt line. For every queue, the line has a separate receive source, set while the queue holds data, and a separate transmit source, set while the queue has room. Both sources latch in a raw status word. Software clears a source by writing one to its status bit. Enable bits are changed only through a set register and a clear register. The line is high while any enabled source is set, so any queue can be tied to any processor.

The bus carries one access per cycle. A write takes effect on the clock edge. Read data is registered and appears the cycle after the read strobe; a write strobe in the same cycle wins over a read. The whole map sits inside a 0x200-byte window.

Top module: `mbox_top`

## Requirements
- R1: Words written to the message register of queue q (byte address 0x040 + 4q) are returned in first-in first-out order by reads of that same address, and each read removes one word. A queue holds 4 words of 32 bits.
- R2: A write to a full queue is dropped, leaving the count and contents unchanged. It sets a sticky overflow flag, seen at bit 16 of the count register. Writing a word with bit 16 set to the count register clears the flag.
- R3: A read of an empty queue's message register returns zero and leaves the count unchanged.
- R4: The count register of queue q (0x080 + 4q) returns the number of stored words in bits [2:0]. The full register (0x0C0 + 4q) returns 1 in bit 0 when the queue holds 4 words. All other bits of both registers read zero.
- R5: The raw status word of user u (0x100 + 0x10u) has bit 2q for the receive source of queue q and bit 2q+1 for its transmit source. In a cycle where queue q holds a word, its receive bit is set at the next edge. In a cycle where queue q is not full, its transmit bit is set at the next edge. A set bit stays set until cleared, and every user sees the same events.
- R6: Writing 1 to a raw status bit clears it at that edge, taking priority over a new event. If the condition still holds, the bit sets again on the following edge.
- R7: Writing 1 to bits of the enable-set register (user offset +0x8) sets those enable bits. Writing 1 to the enable-clear register (+0xC) clears them. Reading either register returns the enable word. The enabled-status register (+0x4) reads raw status AND enable.
- R8: The interrupt line of user u is high exactly when raw status AND enable of that user is non-zero.
- R9: Reads of registers for queues or users that do not exist, of unmapped offsets, or of byte addresses that are not word-aligned return zero. Writes to such addresses change nothing.
- R10: After reset, all queues are empty, overflow flags, status and enables are zero, the read data output is zero and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_re | input | 1 | Read strobe for one cycle (ignored when bus_we is high) |
| bus_addr | input | 9 | Byte address inside the 0x200 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| irq | output | NU | Level interrupt, one line per user |

## Verification
The hardest state to reach is the interplay between a latched source and a condition that is still true. Examples are a transmit bit cleared while its queue is still non-full, a receive bit cleared while data remains, and a transmit bit cleared while the queue is full, where the bit must stay low. Directed sequences reach these states: the bench fills a queue past capacity, clears status bits between pushes and pops, and reads raw status in the cycle right after a clear. A long random phase then mixes pushes, pops, clears and enable changes over every queue and user. A behavioural model checks every interrupt line on every cycle, so a source that re-arms one cycle early or late is caught.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 9;
    localparam int OVF_BIT = 16;

    typedef enum logic [2:0] {
        REGION_NONE,
        REGION_MSG,
        REGION_CNT,
        REGION_FULL,
        REGION_USER
    } region_e;

    typedef enum logic [1:0] {
        UREG_RAW    = 2'd0,
        UREG_MASKED = 2'd1,
        UREG_ENSET  = 2'd2,
        UREG_ENCLR  = 2'd3
    } ureg_e;

    typedef struct packed {
        region_e    region;
        logic [3:0] idx;
        ureg_e      ureg;
    } dec_t;

    function automatic dec_t decode(logic [ADDR_W-1:0] a);
        dec_t d;
        d.region = REGION_NONE;
        d.idx    = a[5:2];
        d.ureg   = ureg_e'(a[3:2]);
        if (a[1:0] == 2'b00) begin
            if (a[8]) begin
                d.region = REGION_USER;
                d.idx    = a[7:4];
            end else begin
                case (a[7:6])
                    2'b01:   d.region = REGION_MSG;
                    2'b10:   d.region = REGION_CNT;
                    2'b11:   d.region = REGION_FULL;
                    default: d.region = REGION_NONE;
                endcase
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     wdata,
    input  logic             ovf_clr,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             ovf
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rp];

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push && full)  ovf <= 1'b1;
            else if (ovf_clr)  ovf <= 1'b0;
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_full_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)) && ovf);

    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0));

endmodule

// File: rtl/mbox_user.sv
module mbox_user #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] cond,
    input  logic [SW-1:0] clr_mask,
    input  logic [SW-1:0] en_set,
    input  logic [SW-1:0] en_clr,
    output logic [SW-1:0] status,
    output logic [SW-1:0] enable,
    output logic          irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status | cond) & ~clr_mask;
            enable <= (enable | en_set) & ~en_clr;
        end
    end

    assign irq = |(status & enable);

    assert_latch_R5: assert property (@(posedge clk) disable iff (rst)
        ((cond & ~clr_mask) != '0) |=>
        ((status & $past(cond & ~clr_mask)) == $past(cond & ~clr_mask)));

    assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0) |=> ((status & $past(clr_mask)) == '0));

    assert_en_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> !irq);

endmodule

// File: rtl/mbox_top.sv
module mbox_top
    import mbox_pkg::*;
#(
    parameter int NQ    = 8,
    parameter int NU    = 3,
    parameter int DEPTH = 4,
    localparam int SW    = 2 * NQ,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NU-1:0]     irq
);

    dec_t              dec;
    logic              wr, rd;
    logic [DATA_W-1:0] rd_val;

    logic [DATA_W-1:0] q_head  [NQ];
    logic [CNT_W-1:0]  q_count [NQ];
    logic [NQ-1:0]     q_full, q_empty, q_ovf;
    logic [SW-1:0]     cond;

    logic [SW-1:0]     u_status [NU];
    logic [SW-1:0]     u_enable [NU];

    assign dec = decode(bus_addr);
    assign wr  = bus_we;
    assign rd  = bus_re && !bus_we;

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        logic hit;
        assign hit = (dec.idx == 4'(q));

        mbox_fifo #(.DEPTH(DEPTH), .W(DATA_W)) fifo_i (
            .clk     (clk),
            .rst     (rst),
            .push    (wr && hit && dec.region == REGION_MSG),
            .pop     (rd && hit && dec.region == REGION_MSG),
            .wdata   (bus_wdata),
            .ovf_clr (wr && hit && dec.region == REGION_CNT && bus_wdata[OVF_BIT]),
            .head    (q_head[q]),
            .count   (q_count[q]),
            .full    (q_full[q]),
            .empty   (q_empty[q]),
            .ovf     (q_ovf[q])
        );

        assign cond[2*q]   = !q_empty[q];
        assign cond[2*q+1] = !q_full[q];
    end

    for (genvar u = 0; u < NU; u++) begin : g_user
        logic urw;
        assign urw = wr && dec.region == REGION_USER && dec.idx == 4'(u);

        mbox_user #(.SW(SW)) user_i (
            .clk      (clk),
            .rst      (rst),
            .cond     (cond),
            .clr_mask ((urw && dec.ureg == UREG_RAW)   ? bus_wdata[SW-1:0] : '0),
            .en_set   ((urw && dec.ureg == UREG_ENSET) ? bus_wdata[SW-1:0] : '0),
            .en_clr   ((urw && dec.ureg == UREG_ENCLR) ? bus_wdata[SW-1:0] : '0),
            .status   (u_status[u]),
            .enable   (u_enable[u]),
            .irq      (irq[u])
        );
    end

    always_comb begin
        rd_val = '0;
        case (dec.region)
            REGION_MSG: begin
                for (int q = 0; q < NQ; q++)
                    if (dec.idx == 4'(q)) rd_val = q_head[q];
            end
            REGION_CNT: begin
                for (int q = 0; q < NQ; q++)
                    if (dec.idx == 4'(q)) begin
                        rd_val[CNT_W-1:0] = q_count[q];
                        rd_val[OVF_BIT]   = q_ovf[q];
                    end
            end
            REGION_FULL: begin
                for (int q = 0; q < NQ; q++)
                    if (dec.idx == 4'(q)) rd_val[0] = q_full[q];
            end
            REGION_USER: begin
                for (int u = 0; u < NU; u++)
                    if (dec.idx == 4'(u)) begin
                        case (dec.ureg)
                            UREG_RAW:    rd_val[SW-1:0] = u_status[u];
                            UREG_MASKED: rd_val[SW-1:0] = u_status[u] & u_enable[u];
                            default:     rd_val[SW-1:0] = u_enable[u];
                        endcase
                    end
            end
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_val;
    end

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (irq == '0) && (bus_rdata == '0));

    assert_read_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(bus_rdata));

endmodule

// File: tb/mbox_top_tb_top.sv
module mbox_top_tb_top;

    localparam int NQ    = 8;
    localparam int NU    = 3;
    localparam int DEPTH = 4;
    localparam int SW    = 2 * NQ;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0, bus_re = 1'b0;
    logic [8:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NU-1:0] irq;

    always #2 clk = ~clk;

    mbox_top #(.NQ(NQ), .NU(NU), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    int n_checks = 0;
    int n_fails  = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    int            mq [NQ][$];
    bit            movf [NQ];
    bit [SW-1:0]   mstat [NU];
    bit [SW-1:0]   men [NU];
    logic [NU-1:0] exp_irq = '0;
    logic [31:0]   exp_rd;
    bit            pend = 0;
    string         cur_tag = "R1";
    string         exp_tag = "R1";

    always @(posedge clk) begin : model
        bit [SW-1:0] cnd, clr, es, ec;
        logic [31:0] rv;
        int a, qi, ui;
        a = int'(bus_addr);
        if (rst) begin
            for (int q = 0; q < NQ; q++) begin mq[q].delete(); movf[q] = 0; end
            for (int u = 0; u < NU; u++) begin mstat[u] = '0; men[u] = '0; end
            pend = 0;
            exp_irq = '0;
        end else begin
            cnd = '0;
            for (int q = 0; q < NQ; q++) begin
                cnd[2*q]   = (mq[q].size() != 0);
                cnd[2*q+1] = (mq[q].size() < DEPTH);
            end
            pend = 0;
            if (bus_re && !bus_we) begin
                rv = '0;
                if (a % 4 == 0) begin
                    if (a >= 'h40 && a < 'h40 + 4*NQ) begin
                        qi = (a - 'h40) / 4;
                        if (mq[qi].size() != 0) rv = mq[qi].pop_front();
                    end else if (a >= 'h80 && a < 'h80 + 4*NQ) begin
                        qi = (a - 'h80) / 4;
                        rv = mq[qi].size();
                        rv[16] = movf[qi];
                    end else if (a >= 'hC0 && a < 'hC0 + 4*NQ) begin
                        qi = (a - 'hC0) / 4;
                        rv = (mq[qi].size() == DEPTH) ? 1 : 0;
                    end else if (a >= 'h100 && a < 'h100 + 16*NU) begin
                        ui = (a - 'h100) / 16;
                        case ((a / 4) % 4)
                            0: rv = 32'(mstat[ui]);
                            1: rv = 32'(mstat[ui] & men[ui]);
                            default: rv = 32'(men[ui]);
                        endcase
                    end
                end
                exp_rd = rv;
                exp_tag = cur_tag;
                pend = 1;
            end
            for (int u = 0; u < NU; u++) begin
                clr = (bus_we && a == 'h100 + 16*u)     ? bus_wdata[SW-1:0] : '0;
                es  = (bus_we && a == 'h100 + 16*u + 8) ? bus_wdata[SW-1:0] : '0;
                ec  = (bus_we && a == 'h100 + 16*u + 12)? bus_wdata[SW-1:0] : '0;
                mstat[u] = (mstat[u] | cnd) & ~clr;
                men[u]   = (men[u] | es) & ~ec;
            end
            if (bus_we && a % 4 == 0) begin
                if (a >= 'h40 && a < 'h40 + 4*NQ) begin
                    qi = (a - 'h40) / 4;
                    if (mq[qi].size() < DEPTH) mq[qi].push_back(int'(bus_wdata));
                    else movf[qi] = 1;
                end else if (a >= 'h80 && a < 'h80 + 4*NQ) begin
                    qi = (a - 'h80) / 4;
                    if (bus_wdata[16]) movf[qi] = 0;
                end
            end
            for (int u = 0; u < NU; u++) exp_irq[u] = |(mstat[u] & men[u]);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R8 irq", 32'(irq), 32'(exp_irq));
            if (pend) begin
                check(exp_tag, bus_rdata, exp_rd);
                pend = 0;
            end
        end
    end

    task automatic wr(int a, logic [31:0] d);
        bus_addr = 9'(a); bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(int a, string tag);
        cur_tag = tag;
        bus_addr = 9'(a); bus_re = 1'b1; bus_we = 1'b0;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    function automatic string tag_for(int a);
        if (a >= 'h40 && a < 'h80)  return "R1 msg";
        if (a >= 'h80 && a < 'h100) return "R4 cnt/full";
        if (a >= 'h100 && (a % 16) == 0) return "R5 raw";
        if (a >= 'h100) return "R7 enable";
        return "R9 none";
    endfunction

    bit done = 0;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (5) @(negedge clk);
        rst = 1'b0;
        check("R10 irq after reset", 32'(irq), '0);
        check("R10 rdata after reset", bus_rdata, '0);
        @(negedge clk);
        check("R10 irq with enables clear", 32'(irq), '0);

        rd('h100, "R5 tx bits after reset");
        rd('h080, "R10 count empty");
        rd('h084, "R10 count empty");

        wr('h108, 32'h0000_0001);          // user0: rx q0
        wr('h118, 32'h0000_0020);          // user1: tx q2
        wr('h128, 32'h0000_0004);          // user2: rx q1
        rd('h118, "R7 enable readback");
        rd('h114, "R7 masked");
        wr('h110, 32'h0000_0020);          // clear tx q2 of user1
        rd('h110, "R6 raw right after clear");
        rd('h110, "R6 raw re-set");

        for (int i = 0; i < 5; i++) wr('h040, 32'hA000_0000 + i);
        rd('h080, "R2 overflow and count");
        rd('h0C0, "R4 full flag");
        wr('h100, 32'h0000_0003);          // clear rx/tx of q0 at user0
        rd('h100, "R6 raw after clear while full");
        rd('h100, "R6 tx stays clear while full");
        for (int i = 0; i < 4; i++) rd('h040, "R1 fifo order");
        rd('h040, "R3 empty read zero");
        rd('h080, "R3 count unchanged, R2 sticky");
        wr('h080, 32'h0001_0000);
        rd('h080, "R2 overflow cleared");
        wr('h100, 32'h0000_0001);
        rd('h100, "R6 rx clear after drain");

        wr('h044, 32'h1234_5678);
        rd('h124, "R7 masked user2");
        wr('h12C, 32'h0000_0004);
        rd('h128, "R7 enable cleared");
        rd('h044, "R1 single word");

        wr('h060, 32'hDEAD_BEEF);          // queue 8: absent
        rd('h060, "R9 absent queue");
        rd('h0A0, "R9 absent count");
        wr('h130, 32'hFFFF_FFFF);
        rd('h130, "R9 absent user");
        rd('h000, "R9 unmapped");
        rd('h041, "R9 unaligned");
        wr('h049, 32'h5555_5555);
        rd('h088, "R9 unaligned write ignored");

        for (int n = 0; n < 600; n++) begin
            int k, a;
            k = $urandom_range(0, 9);
            case (k)
                0, 1: a = 'h40 + 4 * $urandom_range(0, NQ - 1);
                2:    a = 'h80 + 4 * $urandom_range(0, NQ - 1);
                3:    a = 'hC0 + 4 * $urandom_range(0, NQ - 1);
                default: a = 'h100 + 16 * $urandom_range(0, NU - 1) + 4 * $urandom_range(0, 3);
            endcase
            if ($urandom_range(0, 1) == 0) begin
                if (a >= 'h40 && a < 'h80 && $urandom_range(0, 2) == 0)
                    for (int j = 0; j < 3; j++) wr(a, $urandom);
                else
                    wr(a, $urandom);
            end else begin
                rd(a, tag_for(a));
            end
        end

        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule